// File: doc/BRIEF.md
# Vector Sub-PC Loop Sequencer

This block owns the program counter and the element-step counter of a scalar core that has a prefixed vector mode. For each instruction, it inspects the prefix word to decide whether the instruction is prefixed. The next-instruction address is the current address plus 8 for a prefixed instruction and plus 4 for a plain one.

For a prefixed instruction whose destination is marked as vector, the block repeats the same instruction once per element. During this loop the PC stays where it is and the element step counts upward from zero. When the last element (VL-1) retires, the step returns to zero and the PC moves on.

The register numbers of vector-flagged operands are offset by the current step. Scalar operands keep their base numbers, so a scalar source feeds every element. A scalar destination ends the loop after element 0. The execute stage raises `step_i` once per issued instruction or element and uses the effective register numbers in the same cycle.

Top module: `vec_subpc_seq`

## Requirements
- R1: `pfx_o` is 1 exactly when `prefix_i[31:26]` equals 6'b000001 and `prefix_i[24]` and `prefix_i[22]` are both 1; all other words are plain.
- R2: On a `step_i` cycle with a plain word, the PC advances by 4 and the step ends at zero.
- R3: While `rst_ni` is low, `pc_o` equals the parameter `PC_INIT` and `step_o` is zero.
- R4: A vector-flagged operand's effective register number is (base + step) mod 32 when prefixed, else the base; a scalar-flagged operand always uses its base.
- R5: When prefixed, destination vector and step+1 < VL, `nia_o` equals `pc_o` and a `step_i` cycle increments the step while the PC holds.
- R6: When prefixed with a vector destination and step = VL-1, a `step_i` cycle advances the PC by 8 and clears the step.
- R7: When prefixed with a scalar destination, one `step_i` cycle advances the PC by 8 with step zero; only element 0 is written, so registers above the destination stay unmodified.
- R8: When prefixed with VL of 0 or 1, one element executes and the PC then advances by 8.
- R9: With `step_i` low, PC and step hold their values, including in the middle of a loop.
- R10: With a scalar source and a vector destination, each element reads the same source register while the destination number advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One issued instruction or element retires this cycle |
| prefix_i | input | 32 | Prefix word of the current instruction |
| vl_i | input | 7 | Vector length |
| src_reg_i | input | NUM_SRC*5 | Source base register numbers, source 0 in the low bits |
| src_vec_i | input | NUM_SRC | Per-source vector flag |
| dst_reg_i | input | 5 | Destination base register number |
| dst_vec_i | input | 1 | Destination vector flag |
| src_eff_o | output | NUM_SRC*5 | Effective source register numbers |
| dst_eff_o | output | 5 | Effective destination register number |
| pfx_o | output | 1 | Prefix detected |
| step_o | output | 7 | Current element step |
| pc_o | output | 64 | Current instruction address |
| nia_o | output | 64 | Next instruction address |

## Verification
The assertions assume that the prefix word, VL, and the operand fields stay stable over every element of a loop. They also assume that VL does not drop below the running step partway through a loop. The stimulus keeps to these assumptions by holding all instruction inputs fixed until the model reports that the PC has moved. The only change it makes between elements is to deassert `step_i` for stall cycles. A small register file with an adder in the bench applies the effective numbers, so that element results and untouched registers can be checked.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam logic [5:0]  PFX_MAJOR   = 6'b000001;
  localparam int unsigned PFX_FLAG_A  = 24;
  localparam int unsigned PFX_FLAG_B  = 22;
  localparam int unsigned INC_W       = 4;
  localparam logic [INC_W-1:0] INC_PLAIN  = 4'd4;
  localparam logic [INC_W-1:0] INC_PREFIX = 4'd8;

  typedef struct packed {
    logic             hit;
    logic [INC_W-1:0] inc;
  } pfx_info_t;
endpackage

// File: rtl/vsp_prefix_detect.sv
module vsp_prefix_detect
  import vsp_pkg::*;
(
  input  logic [31:0] word_i,
  output pfx_info_t   info_o
);
  logic unused_word;
  assign unused_word = ^{word_i[25], word_i[23], word_i[21:0]};

  always_comb begin
    info_o.hit = (word_i[31:26] == PFX_MAJOR) && word_i[PFX_FLAG_A] && word_i[PFX_FLAG_B];
    info_o.inc = info_o.hit ? INC_PREFIX : INC_PLAIN;
  end
endmodule

// File: rtl/vsp_reg_remap.sv
module vsp_reg_remap #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] base_i,
  input  logic              vec_i,
  input  logic [REG_AW-1:0] step_i,
  output logic [REG_AW-1:0] eff_o
);
  // wraps modulo 2**REG_AW
  assign eff_o = vec_i ? base_i + step_i : base_i;
endmodule

// File: rtl/vsp_step_ctrl.sv
module vsp_step_ctrl
  import vsp_pkg::*;
#(
  parameter int unsigned    XLEN    = 64,
  parameter int unsigned    STEP_W  = 7,
  parameter logic [XLEN-1:0] PC_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              hit_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              dst_vec_i,
  input  logic [STEP_W-1:0] vl_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   nia_o,
  output logic [STEP_W-1:0] step_o
);
  localparam int unsigned CMP_W = STEP_W + 1;

  logic [XLEN-1:0]   pc_q;
  logic [STEP_W-1:0] step_q;
  logic [CMP_W-1:0]  step_nxt_w;
  logic              more_elems;

  assign step_nxt_w = {1'b0, step_q} + CMP_W'(1);
  // loop continues only for a vector destination with elements left
  assign more_elems = hit_i && dst_vec_i && (step_nxt_w < {1'b0, vl_i});
  assign nia_o      = more_elems ? pc_q : pc_q + XLEN'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= PC_INIT;
      step_q <= '0;
    end else if (step_i) begin
      pc_q   <= nia_o;
      step_q <= more_elems ? step_nxt_w[STEP_W-1:0] : '0;
    end
  end

  assign pc_o   = pc_q;
  assign step_o = step_q;
endmodule

// File: rtl/vec_subpc_seq.sv
module vec_subpc_seq
  import vsp_pkg::*;
#(
  parameter int unsigned     XLEN    = 64,
  parameter int unsigned     STEP_W  = 7,
  parameter int unsigned     REG_AW  = 5,
  parameter int unsigned     NUM_SRC = 2,
  parameter logic [XLEN-1:0] PC_INIT = 64'h1000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      step_i,
  input  logic [31:0]               prefix_i,
  input  logic [STEP_W-1:0]         vl_i,
  input  logic [NUM_SRC*REG_AW-1:0] src_reg_i,
  input  logic [NUM_SRC-1:0]        src_vec_i,
  input  logic [REG_AW-1:0]         dst_reg_i,
  input  logic                      dst_vec_i,
  output logic [NUM_SRC*REG_AW-1:0] src_eff_o,
  output logic [REG_AW-1:0]         dst_eff_o,
  output logic                      pfx_o,
  output logic [STEP_W-1:0]         step_o,
  output logic [XLEN-1:0]           pc_o,
  output logic [XLEN-1:0]           nia_o
);
  pfx_info_t         info;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_eff;
  logic unused_step;

  vsp_prefix_detect u_pfx (
    .word_i (prefix_i),
    .info_o (info)
  );

  vsp_step_ctrl #(
    .XLEN    (XLEN),
    .STEP_W  (STEP_W),
    .PC_INIT (PC_INIT)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .hit_i     (info.hit),
    .inc_i     (info.inc),
    .dst_vec_i (dst_vec_i),
    .vl_i      (vl_i),
    .pc_o      (pc_o),
    .nia_o     (nia_o),
    .step_o    (step_q)
  );

  // plain instructions index with element zero
  assign step_eff    = info.hit ? step_q : '0;
  assign unused_step = ^step_eff[STEP_W-1:REG_AW];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    vsp_reg_remap #(.REG_AW(REG_AW)) u_src (
      .base_i (src_reg_i[g*REG_AW +: REG_AW]),
      .vec_i  (src_vec_i[g]),
      .step_i (step_eff[REG_AW-1:0]),
      .eff_o  (src_eff_o[g*REG_AW +: REG_AW])
    );
  end

  vsp_reg_remap #(.REG_AW(REG_AW)) u_dst (
    .base_i (dst_reg_i),
    .vec_i  (dst_vec_i),
    .step_i (step_eff[REG_AW-1:0]),
    .eff_o  (dst_eff_o)
  );

  assign pfx_o  = info.hit;
  assign step_o = step_q;
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned STEP_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_i,
  input logic              dst_vec_i,
  input logic [STEP_W-1:0] vl_i,
  input logic              pfx_o,
  input logic [STEP_W-1:0] step_o,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   nia_o
);
  logic [STEP_W:0] step_p1;
  assign step_p1 = {1'b0, step_o} + 1'b1;

  p_plain_adv4_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !pfx_o |=> pc_o == $past(pc_o) + XLEN'(4) && step_o == '0);

  p_loop_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && pfx_o && dst_vec_i && (step_p1 < {1'b0, vl_i})
    |=> pc_o == $past(pc_o) && step_o == $past(step_o) + 1'b1);

  p_loop_nia_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfx_o && dst_vec_i && (step_p1 < {1'b0, vl_i}) |-> nia_o == pc_o);

  p_last_elem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && pfx_o && dst_vec_i && (step_p1 == {1'b0, vl_i})
    |=> pc_o == $past(pc_o) + XLEN'(8) && step_o == '0);

  p_scalar_dst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && pfx_o && !dst_vec_i |=> pc_o == $past(pc_o) + XLEN'(8) && step_o == '0);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o) && $stable(step_o));
endmodule

bind vec_subpc_seq vsp_checker #(.XLEN(XLEN), .STEP_W(STEP_W)) u_chk (.*);

// File: tb/tb_vec_subpc_seq.sv
module tb_vec_subpc_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PC0 = 64'h1000;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        step_i = 0;
  logic [31:0] prefix_i = '0;
  logic [6:0]  vl_i = '0;
  logic [9:0]  src_reg_i = '0;
  logic [1:0]  src_vec_i = '0;
  logic [4:0]  dst_reg_i = '0;
  logic        dst_vec_i = 0;
  logic [9:0]  src_eff_o;
  logic [4:0]  dst_eff_o;
  logic        pfx_o;
  logic [6:0]  step_o;
  logic [63:0] pc_o, nia_o;

  vec_subpc_seq #(.PC_INIT(PC0)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  longint m_pc;
  int     m_step;
  logic [63:0] rf [32];

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mkpfx(logic [5:0] maj, logic a, logic b);
    return {maj, 1'b0, a, 1'b0, b, 22'h0};
  endfunction

  // one cycle against the behavioural model; returns 1 if PC moved
  task automatic apply(input logic stb, output bit moved);
    bit hit, stay;
    int st, s0, s1, d, ve;
    longint nia;
    step_i = stb;
    #2;
    hit = (prefix_i[31:26] == 6'd1) && prefix_i[24] && prefix_i[22];
    st  = hit ? m_step : 0;
    s0  = src_vec_i[0] ? (src_reg_i[4:0] + st) % 32 : src_reg_i[4:0];
    s1  = src_vec_i[1] ? (src_reg_i[9:5] + st) % 32 : src_reg_i[9:5];
    d   = dst_vec_i ? (dst_reg_i + st) % 32 : dst_reg_i;
    ve  = vl_i;
    stay = hit && dst_vec_i && (m_step + 1 < ve);
    nia = stay ? m_pc : m_pc + (hit ? 8 : 4);
    chk("R1 pfx", pfx_o, hit);
    chk("R4 src0", src_eff_o[4:0], s0);
    chk("R4 src1", src_eff_o[9:5], s1);
    chk("R4 dst", dst_eff_o, d);
    chk("R5 nia", nia_o, nia);
    chk("R2 pc", pc_o, m_pc);
    chk("R6 step", step_o, m_step);
    @(posedge clk_i);
    moved = 0;
    if (stb) begin
      rf[d] = rf[s0] + rf[s1];  // harness adder
      moved = (nia != m_pc);
      m_pc = nia;
      m_step = stay ? m_step + 1 : 0;
    end
    @(negedge clk_i);
  endtask

  task automatic set_insn(logic [31:0] pw, int vl, int d, bit dv, int a, bit av, int b, bit bv);
    prefix_i = pw; vl_i = 7'(vl);
    dst_reg_i = 5'(d); dst_vec_i = dv;
    src_reg_i = {5'(b), 5'(a)}; src_vec_i = {bv, av};
  endtask

  task automatic run_insn(output int elems);
    bit mv;
    elems = 0;
    mv = 0;
    while (!mv && elems < 200) begin
      apply(1, mv);
      elems++;
    end
  endtask

  task automatic init_rf();
    for (int i = 0; i < 32; i++) rf[i] = '0;
    rf[5] = 64'h4321; rf[6] = 64'h2223; rf[9] = 64'h1234; rf[10] = 64'h1111;
  endtask

  logic [31:0] VP;
  int ne;
  bit mv;

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    VP = mkpfx(6'd1, 1, 1);
    init_rf();
    m_pc = PC0; m_step = 0;
    repeat (3) @(negedge clk_i);
    chk("R3 pc", pc_o, PC0);
    chk("R3 step", step_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 plain and near-miss words
    set_insn(32'h0, 2, 3, 1, 4, 1, 7, 0);              run_insn(ne); chk("R2 elems", ne, 1);
    set_insn(mkpfx(6'd1, 1, 0), 4, 3, 1, 4, 1, 7, 1);  run_insn(ne); chk("R1 a-only", ne, 1);
    set_insn(mkpfx(6'd1, 0, 1), 4, 3, 1, 4, 1, 7, 1);  run_insn(ne); chk("R1 b-only", ne, 1);
    set_insn(mkpfx(6'd2, 1, 1), 4, 3, 1, 4, 1, 7, 1);  run_insn(ne); chk("R1 major", ne, 1);
    // R9 idle
    repeat (3) apply(0, mv);

    // R5 R6 all-vector add, VL=2
    init_rf();
    set_insn(VP, 2, 1, 1, 5, 1, 9, 1); run_insn(ne);
    chk("R5 elems", ne, 2);
    chk("R6 r1", rf[1], 64'h5555);
    chk("R6 r2", rf[2], 64'h3334);

    // R7 scalar destination
    init_rf();
    set_insn(VP, 2, 1, 0, 5, 1, 9, 1); run_insn(ne);
    chk("R7 elems", ne, 1);
    chk("R7 r1", rf[1], 64'h5555);
    chk("R7 r2", rf[2], 64'h0);

    // R10 scalar source, vector destination
    init_rf();
    set_insn(VP, 2, 1, 1, 5, 0, 9, 1); run_insn(ne);
    chk("R10 r1", rf[1], 64'h5555);
    chk("R10 r2", rf[2], 64'h5432);

    // R8 VL of 0 and 1
    set_insn(VP, 0, 1, 1, 5, 1, 9, 1); run_insn(ne); chk("R8 vl0", ne, 1);
    set_insn(VP, 1, 1, 1, 5, 1, 9, 1); run_insn(ne); chk("R8 vl1", ne, 1);

    // R4 wrap modulo 32, VL=4
    set_insn(VP, 4, 30, 1, 29, 1, 3, 0); run_insn(ne); chk("R4 elems", ne, 4);

    // R9 stall in mid-loop, VL=3
    set_insn(VP, 3, 12, 1, 20, 1, 24, 1);
    apply(1, mv);
    chk("R9 mid step", step_o, 1);
    apply(0, mv); apply(0, mv);
    chk("R9 held step", step_o, 1);
    run_insn(ne); chk("R9 rest", ne, 2);

    // long loop VL=40
    set_insn(VP, 40, 0, 1, 8, 1, 16, 0); run_insn(ne); chk("R6 vl40", ne, 40);
    set_insn(32'h0, 0, 2, 0, 3, 0, 4, 0); run_insn(ne); chk("R2 after", ne, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule